// File: doc/BRIEF.md
# Keyboard Controller Host Command Decoder

This block is the host-facing front end of a legacy PC keyboard controller. The host reaches it through two byte-wide write strobes. One is for the data port and one is for the command/status port. Each command byte is decoded in the cycle it arrives. Some commands act at once: they set or clear mode bits, move the A20 gate, request a system reset or queue a reply byte. Others are two-phase: they arm a pending-command latch, and the latch decides where the next data-port byte goes.

The block keeps three registers: the mode register, the output port register and the status bits it owns. It drives the A20 gate as a registered level and the system reset request as a single-clock pulse. Reply bytes leave through one-cycle push strobes toward a keyboard-side queue and a mouse-side queue. Bytes meant for the attached devices leave through two more push strobes. The queue storage, the serial device protocols and the interrupt logic sit outside. Those parts receive a one-cycle refresh pulse whenever a change might affect the interrupt enables.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset, mode_o is 0x03, status_o is 0x18 and outport_o is 0xCF. a20_o is 1, and every push, sys_reset_req and irq_refresh are 0. In status_o, bit 4 is always 1; bits 0, 1, 5, 6 and 7 are always 0; bit 2 is the self-test flag and bit 3 is the command flag.
- R2: A command of 0x60, 0xD1, 0xD2, 0xD3 or 0xD4 arms the pending latch. The next data-port byte then goes, in that order of codes, to: the mode register, the output port register, the keyboard queue, the mouse queue, or the mouse device push.
- R3: A data-port byte with no armed latch is pushed to the keyboard device (kdev_push, kdev_byte). Every data-port write disarms the latch.
- R4: Any command from 0xF0 to 0xFF with bit 0 clear gives a one-cycle sys_reset_req. With bit 0 set, the command has no effect.
- R5: Reply commands push one byte onto the keyboard queue: 0x20 pushes the mode register, 0xD0 the output port register, 0xC0 the value 0x80, and 0xA9 and 0xAB push 0x00.
- R6: Command 0xAA sets status bit 2 and pushes 0x55 onto the keyboard queue.
- R7: 0xA7 sets and 0xA8 clears mode bit 5. 0xAD sets and 0xAE clears mode bit 4. 0xAD, 0xAE and a mode-register data write each pulse irq_refresh for one cycle.
- R8: 0xDF sets outport bit 1 and drives a20_o high. 0xDD clears outport bit 1 and drives a20_o low.
- R9: A data byte written to the output port sets a20_o from its bit 1. If its bit 0 is 0, it also pulses sys_reset_req.
- R10: xlate_en always equals mode register bit 6.
- R11: A command-port write sets status bit 3. A data-port write clears it.
- R12: A command not listed in R2 to R8 changes no register and causes no push. Like every non-latching command, it leaves an armed latch in place.
- R13: When cmd_wr and data_wr are high in the same cycle, the command is taken and the data byte is dropped. At most one push strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wdata | input | 8 | Written byte |
| status_o | output | 8 | Status byte |
| mode_o | output | 8 | Mode register |
| outport_o | output | 8 | Output port register |
| a20_o | output | 1 | A20 gate level |
| sys_reset_req | output | 1 | One-cycle system reset request |
| xlate_en | output | 1 | Scan-code translation enable |
| irq_refresh | output | 1 | One-cycle interrupt re-evaluation pulse |
| kq_push | output | 1 | Keyboard queue push |
| kq_byte | output | 8 | Keyboard queue byte |
| mq_push | output | 1 | Mouse queue push |
| mq_byte | output | 8 | Mouse queue byte |
| kdev_push | output | 1 | Byte to keyboard device |
| kdev_byte | output | 8 | Keyboard device byte |
| mdev_push | output | 1 | Byte to mouse device |
| mdev_byte | output | 8 | Mouse device byte |

## Verification
The checker watches the following on every cycle:
- the command flag in the status byte, after command and data writes;
- the reset pulse that follows each even pulse-family command, and its absence after odd ones;
- the A20 level against output port bit 1;
- that the latch is disarmed after each accepted data byte;
- that push strobes never overlap;
- the fixed status bits.

Other behaviour shows only in the bench scenarios. A sweep over all 256 command bytes, each followed by a data byte, checks where each latch routes that byte and each reply value. Directed cases check that a latch survives unrelated commands, cover the output-port write cases, and check that a colliding data byte is dropped.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  localparam byte_t C_RD_MODE  = 8'h20;
  localparam byte_t C_WR_MODE  = 8'h60;
  localparam byte_t C_MDIS     = 8'hA7;
  localparam byte_t C_MEN      = 8'hA8;
  localparam byte_t C_MTEST    = 8'hA9;
  localparam byte_t C_SELFTEST = 8'hAA;
  localparam byte_t C_KTEST    = 8'hAB;
  localparam byte_t C_KDIS     = 8'hAD;
  localparam byte_t C_KEN      = 8'hAE;
  localparam byte_t C_RD_IN    = 8'hC0;
  localparam byte_t C_RD_OUT   = 8'hD0;
  localparam byte_t C_WR_OUT   = 8'hD1;
  localparam byte_t C_WR_KOB   = 8'hD2;
  localparam byte_t C_WR_MOB   = 8'hD3;
  localparam byte_t C_WR_MDEV  = 8'hD4;
  localparam byte_t C_A20_OFF  = 8'hDD;
  localparam byte_t C_A20_ON   = 8'hDF;

  localparam int MB_KDIS  = 4;
  localparam int MB_MDIS  = 5;
  localparam int MB_XLATE = 6;
  localparam int OB_RUN   = 0;
  localparam int OB_A20   = 1;
  localparam int SB_TEST  = 2;
  localparam int SB_CMD   = 3;
  localparam int SB_UNLK  = 4;

  typedef enum logic [2:0] {
    PEND_NONE  = 3'd0,
    PEND_MODE  = 3'd1,
    PEND_OUTP  = 3'd2,
    PEND_KOBUF = 3'd3,
    PEND_MOBUF = 3'd4,
    PEND_MDEV  = 3'd5
  } pend_e;

  typedef enum logic [1:0] {REP_CONST, REP_MODE, REP_OUTP} rep_src_e;

  typedef struct packed {
    logic     pend_load;
    pend_e    pend_val;
    logic     reply_en;
    rep_src_e reply_src;
    byte_t    reply_const;
    byte_t    mode_or;
    byte_t    mode_andn;
    logic     irq_ref;
    byte_t    outp_or;
    byte_t    outp_andn;
    logic     a20_touch;
    logic     a20_val;
    logic     selftest;
    logic     rst_req;
  } cmd_act_t;

  typedef struct packed {
    logic kdev;
    logic mdev;
    logic kq;
    logic mq;
    logic mode_wr;
    logic outp_wr;
  } dat_act_t;

  function automatic logic pulse_family(input byte_t c);
    return c[7:4] == 4'hF;
  endfunction

  function automatic logic pulse_resets(input byte_t c);
    return pulse_family(c) && !c[0];
  endfunction

  function automatic pend_e latch_target(input byte_t c);
    case (c)
      C_WR_MODE: return PEND_MODE;
      C_WR_OUT:  return PEND_OUTP;
      C_WR_KOB:  return PEND_KOBUF;
      C_WR_MOB:  return PEND_MOBUF;
      C_WR_MDEV: return PEND_MDEV;
      default:   return PEND_NONE;
    endcase
  endfunction

  function automatic byte_t bit_mask(input int pos);
    byte_t m;
    m = '0;
    m[pos] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/kbc_cmd_dec.sv
module kbc_cmd_dec
  import kbc_pkg::*;
#(
  parameter byte_t INPORT_VAL  = 8'h80,
  parameter byte_t SELFTEST_OK = 8'h55,
  parameter byte_t TEST_OK     = 8'h00
) (
  input  byte_t    cmd,
  output cmd_act_t act
);
  pend_e tgt;
  assign tgt = latch_target(cmd);

  always_comb begin
    act = '0;
    act.pend_val  = tgt;
    act.pend_load = (tgt != PEND_NONE);
    act.reply_src = REP_CONST;
    if (pulse_family(cmd)) begin
      act.rst_req = pulse_resets(cmd);
    end else begin
      case (cmd)
        C_RD_MODE: begin act.reply_en = 1'b1; act.reply_src = REP_MODE; end
        C_RD_OUT:  begin act.reply_en = 1'b1; act.reply_src = REP_OUTP; end
        C_RD_IN:   begin act.reply_en = 1'b1; act.reply_const = INPORT_VAL; end
        C_MTEST, C_KTEST: begin
          act.reply_en    = 1'b1;
          act.reply_const = TEST_OK;
        end
        C_SELFTEST: begin
          act.reply_en    = 1'b1;
          act.reply_const = SELFTEST_OK;
          act.selftest    = 1'b1;
        end
        C_MDIS: act.mode_or   = bit_mask(MB_MDIS);
        C_MEN:  act.mode_andn = bit_mask(MB_MDIS);
        C_KDIS: begin act.mode_or   = bit_mask(MB_KDIS); act.irq_ref = 1'b1; end
        C_KEN:  begin act.mode_andn = bit_mask(MB_KDIS); act.irq_ref = 1'b1; end
        C_A20_ON: begin
          act.outp_or   = bit_mask(OB_A20);
          act.a20_touch = 1'b1;
          act.a20_val   = 1'b1;
        end
        C_A20_OFF: begin
          act.outp_andn = bit_mask(OB_A20);
          act.a20_touch = 1'b1;
          act.a20_val   = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kbc_data_route.sv
module kbc_data_route
  import kbc_pkg::*;
(
  input  pend_e    pend,
  output dat_act_t route
);
  always_comb begin
    route = '0;
    case (pend)
      PEND_MODE:  route.mode_wr = 1'b1;
      PEND_OUTP:  route.outp_wr = 1'b1;
      PEND_KOBUF: route.kq      = 1'b1;
      PEND_MOBUF: route.mq      = 1'b1;
      PEND_MDEV:  route.mdev    = 1'b1;
      default:    route.kdev    = 1'b1;
    endcase
  end
endmodule

// File: rtl/kbc_regs.sv
module kbc_regs
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST = 8'h03,
  parameter byte_t OUTP_RST = 8'hCF
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_fire,
  input  logic     data_fire,
  input  byte_t    wdata,
  input  cmd_act_t act,
  input  dat_act_t route,
  output pend_e    pend_q,
  output byte_t    mode_q,
  output byte_t    outp_q,
  output logic     cmdf_q,
  output logic     test_q,
  output logic     a20_q,
  output logic     rst_q,
  output logic     irq_q,
  output logic     kq_push_q,
  output byte_t    kq_byte_q,
  output logic     mq_push_q,
  output byte_t    mq_byte_q,
  output logic     kdev_push_q,
  output byte_t    kdev_byte_q,
  output logic     mdev_push_q,
  output byte_t    mdev_byte_q
);
  byte_t reply_b;
  always_comb begin
    case (act.reply_src)
      REP_MODE: reply_b = mode_q;
      REP_OUTP: reply_b = outp_q;
      default:  reply_b = act.reply_const;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q      <= PEND_NONE;
      mode_q      <= MODE_RST;
      outp_q      <= OUTP_RST;
      cmdf_q      <= 1'b1;
      test_q      <= 1'b0;
      a20_q       <= OUTP_RST[OB_A20];
      rst_q       <= 1'b0;
      irq_q       <= 1'b0;
      kq_push_q   <= 1'b0;
      kq_byte_q   <= '0;
      mq_push_q   <= 1'b0;
      mq_byte_q   <= '0;
      kdev_push_q <= 1'b0;
      kdev_byte_q <= '0;
      mdev_push_q <= 1'b0;
      mdev_byte_q <= '0;
    end else begin
      rst_q       <= 1'b0;
      irq_q       <= 1'b0;
      kq_push_q   <= 1'b0;
      mq_push_q   <= 1'b0;
      kdev_push_q <= 1'b0;
      mdev_push_q <= 1'b0;
      if (cmd_fire) begin
        cmdf_q <= 1'b1;
        if (act.pend_load) pend_q <= act.pend_val;
        mode_q <= (mode_q | act.mode_or) & ~act.mode_andn;
        outp_q <= (outp_q | act.outp_or) & ~act.outp_andn;
        if (act.a20_touch) a20_q <= act.a20_val;
        if (act.selftest) test_q <= 1'b1;
        rst_q <= act.rst_req;
        irq_q <= act.irq_ref;
        if (act.reply_en) begin
          kq_push_q <= 1'b1;
          kq_byte_q <= reply_b;
        end
      end else if (data_fire) begin
        cmdf_q <= 1'b0;
        pend_q <= PEND_NONE;
        if (route.mode_wr) begin
          mode_q <= wdata;
          irq_q  <= 1'b1;
        end
        if (route.outp_wr) begin
          outp_q <= wdata;
          a20_q  <= wdata[OB_A20];
          rst_q  <= ~wdata[OB_RUN];
        end
        if (route.kq) begin
          kq_push_q <= 1'b1;
          kq_byte_q <= wdata;
        end
        if (route.mq) begin
          mq_push_q <= 1'b1;
          mq_byte_q <= wdata;
        end
        if (route.kdev) begin
          kdev_push_q <= 1'b1;
          kdev_byte_q <= wdata;
        end
        if (route.mdev) begin
          mdev_push_q <= 1'b1;
          mdev_byte_q <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
#(
  parameter byte_t MODE_RST    = 8'h03,
  parameter byte_t OUTP_RST    = 8'hCF,
  parameter byte_t INPORT_VAL  = 8'h80,
  parameter byte_t SELFTEST_OK = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] status_o,
  output logic [BYTE_W-1:0] mode_o,
  output logic [BYTE_W-1:0] outport_o,
  output logic              a20_o,
  output logic              sys_reset_req,
  output logic              xlate_en,
  output logic              irq_refresh,
  output logic              kq_push,
  output logic [BYTE_W-1:0] kq_byte,
  output logic              mq_push,
  output logic [BYTE_W-1:0] mq_byte,
  output logic              kdev_push,
  output logic [BYTE_W-1:0] kdev_byte,
  output logic              mdev_push,
  output logic [BYTE_W-1:0] mdev_byte
);
  logic     cmd_fire;
  logic     data_fire;
  cmd_act_t act_w;
  dat_act_t route_w;
  pend_e    pend_w;
  logic     cmdf_w;
  logic     test_w;

  // command port wins a same-cycle collision (R13)
  assign cmd_fire  = cmd_wr;
  assign data_fire = data_wr & ~cmd_wr;

  kbc_cmd_dec #(
    .INPORT_VAL  (INPORT_VAL),
    .SELFTEST_OK (SELFTEST_OK),
    .TEST_OK     (8'h00)
  ) u_dec (
    .cmd (wdata),
    .act (act_w)
  );

  kbc_data_route u_route (
    .pend  (pend_w),
    .route (route_w)
  );

  kbc_regs #(
    .MODE_RST (MODE_RST),
    .OUTP_RST (OUTP_RST)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_fire    (cmd_fire),
    .data_fire   (data_fire),
    .wdata       (wdata),
    .act         (act_w),
    .route       (route_w),
    .pend_q      (pend_w),
    .mode_q      (mode_o),
    .outp_q      (outport_o),
    .cmdf_q      (cmdf_w),
    .test_q      (test_w),
    .a20_q       (a20_o),
    .rst_q       (sys_reset_req),
    .irq_q       (irq_refresh),
    .kq_push_q   (kq_push),
    .kq_byte_q   (kq_byte),
    .mq_push_q   (mq_push),
    .mq_byte_q   (mq_byte),
    .kdev_push_q (kdev_push),
    .kdev_byte_q (kdev_byte),
    .mdev_push_q (mdev_push),
    .mdev_byte_q (mdev_byte)
  );

  always_comb begin
    status_o          = '0;
    status_o[SB_UNLK] = 1'b1;
    status_o[SB_CMD]  = cmdf_w;
    status_o[SB_TEST] = test_w;
  end

  assign xlate_en = mode_o[MB_XLATE];
endmodule

// File: rtl/kbc_cmd_decoder_chk.sv
module kbc_cmd_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic       data_wr,
  input logic [7:0] wdata,
  input logic [7:0] status_o,
  input logic [7:0] outport_o,
  input logic       a20_o,
  input logic       sys_reset_req,
  input logic       kq_push,
  input logic       mq_push,
  input logic       kdev_push,
  input logic       mdev_push,
  input logic [2:0] pend
);
  p_cmd_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> status_o[3]);
  p_cmd_flag_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr) |=> !status_o[3]);
  p_pulse_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:4] == 4'hF && !wdata[0]) |=> sys_reset_req);
  p_pulse_odd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:4] == 4'hF && wdata[0]) |=> !sys_reset_req);
  p_a20_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    a20_o == outport_o[1]);
  p_one_push_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kq_push, mq_push, kdev_push, mdev_push}));
  p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cmd_wr) |=> pend == 3'd0);
  p_selftest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata == 8'hAA) |=> (status_o[2] && kq_push));
  p_fixed_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[4] && status_o[1:0] == 2'b00 && status_o[7:5] == 3'b000);
endmodule

bind kbc_cmd_decoder kbc_cmd_decoder_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_wr        (cmd_wr),
  .data_wr       (data_wr),
  .wdata         (wdata),
  .status_o      (status_o),
  .outport_o     (outport_o),
  .a20_o         (a20_o),
  .sys_reset_req (sys_reset_req),
  .kq_push       (kq_push),
  .mq_push       (mq_push),
  .kdev_push     (kdev_push),
  .mdev_push     (mdev_push),
  .pend          (pend_w)
);

// File: tb/sim_kbc_cmd_decoder.sv
module sim_kbc_cmd_decoder;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic data_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] status_o, mode_o, outport_o, kq_byte, mq_byte, kdev_byte, mdev_byte;
  logic a20_o, sys_reset_req, xlate_en, irq_refresh, kq_push, mq_push, kdev_push, mdev_push;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  kbc_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .wdata(wdata),
    .status_o(status_o), .mode_o(mode_o), .outport_o(outport_o), .a20_o(a20_o),
    .sys_reset_req(sys_reset_req), .xlate_en(xlate_en), .irq_refresh(irq_refresh),
    .kq_push(kq_push), .kq_byte(kq_byte), .mq_push(mq_push), .mq_byte(mq_byte),
    .kdev_push(kdev_push), .kdev_byte(kdev_byte), .mdev_push(mdev_push), .mdev_byte(mdev_byte)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cmd_wr = 0; data_wr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input bit c, input bit d, input logic [7:0] b);
    @(negedge clk); cmd_wr = c; data_wr = d; wdata = b;
    @(negedge clk); cmd_wr = 0; data_wr = 0;
  endtask

  // expected queue reply from a freshly reset controller (R5, R6)
  function automatic int reply_of(input logic [7:0] c);
    case (c)
      8'h20: return 8'h03;
      8'hD0: return 8'hCF;
      8'hC0: return 8'h80;
      8'hA9, 8'hAB: return 8'h00;
      8'hAA: return 8'h55;
      default: return -1;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    // reset state R1
    do_reset();
    chk("R1", "mode", mode_o, 8'h03);
    chk("R1", "status", status_o, 8'h18);
    chk("R1", "outport", outport_o, 8'hCF);
    chk("R1", "a20", a20_o, 1);
    chk("R1", "pushes", {kq_push, mq_push, kdev_push, mdev_push, sys_reset_req, irq_refresh}, 0);

    // full sweep over command bytes
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cb;
      int e_mode, e_outp, e_st, e_rep, e_rst, e_irq, e_a20, lat;
      string rq;
      cb = c[7:0];
      do_reset();
      wr(0, 1, 8'h00);
      chk("R3", "kdev push", kdev_push, 1);
      chk("R11", "status after data", status_o, 8'h10);
      e_mode = 8'h03; e_outp = 8'hCF; e_st = 8'h18; e_rst = 0; e_irq = 0; e_a20 = 1;
      e_rep = reply_of(cb);
      rq = "R12";
      if (cb[7:4] == 4'hF) begin e_rst = cb[0] ? 0 : 1; rq = "R4"; end
      if (e_rep >= 0) rq = "R5";
      if (cb == 8'hAA) begin e_st = 8'h1C; rq = "R6"; end
      if (cb == 8'hA7) begin e_mode = 8'h23; rq = "R7"; end
      if (cb == 8'hA8) rq = "R7";
      if (cb == 8'hAD) begin e_mode = 8'h13; e_irq = 1; rq = "R7"; end
      if (cb == 8'hAE) begin e_irq = 1; rq = "R7"; end
      if (cb == 8'hDD) begin e_outp = 8'hCD; e_a20 = 0; rq = "R8"; end
      if (cb == 8'hDF) rq = "R8";
      lat = (cb == 8'h60) ? 1 : (cb == 8'hD1) ? 2 : (cb == 8'hD2) ? 3 :
            (cb == 8'hD3) ? 4 : (cb == 8'hD4) ? 5 : 0;
      if (lat != 0) rq = "R2";
      wr(1, 0, cb);
      chk(rq, $sformatf("cmd %02h mode", cb), mode_o, e_mode);
      chk(rq, $sformatf("cmd %02h outport", cb), outport_o, e_outp);
      chk(rq, $sformatf("cmd %02h status", cb), status_o, e_st);
      chk(rq, $sformatf("cmd %02h a20", cb), a20_o, e_a20);
      chk(rq, $sformatf("cmd %02h reset", cb), sys_reset_req, e_rst);
      chk(rq, $sformatf("cmd %02h irq", cb), irq_refresh, e_irq);
      chk(rq, $sformatf("cmd %02h kq push", cb), kq_push, e_rep >= 0);
      if (e_rep >= 0) chk(rq, $sformatf("cmd %02h reply", cb), kq_byte, e_rep);
      chk(rq, $sformatf("cmd %02h other pushes", cb), {mq_push, kdev_push, mdev_push}, 0);
      // follow-up data byte routed by latch
      wr(0, 1, 8'h5A);
      chk("R11", "status bit3 clear", status_o[3], 0);
      chk(lat == 0 ? "R3" : "R2", $sformatf("cmd %02h kdev", cb), kdev_push, lat == 0);
      chk("R2", $sformatf("cmd %02h kq", cb), {kq_push, kq_byte}, lat == 3 ? 9'h15A : {1'b0, kq_byte});
      chk("R2", $sformatf("cmd %02h mq", cb), {mq_push, mq_byte}, lat == 4 ? 9'h15A : {1'b0, mq_byte});
      chk("R2", $sformatf("cmd %02h mdev", cb), {mdev_push, mdev_byte}, lat == 5 ? 9'h15A : {1'b0, mdev_byte});
      if (lat == 1) begin
        chk("R2", "mode data", mode_o, 8'h5A);
        chk("R10", "xlate", xlate_en, 1);
        chk("R7", "irq on mode write", irq_refresh, 1);
      end
      if (lat == 2) begin
        chk("R9", "outport data", outport_o, 8'h5A);
        chk("R9", "a20 from data", a20_o, 1);
        chk("R9", "reset on bit0 clear", sys_reset_req, 1);
      end
      wr(0, 1, 8'h33);
      chk("R3", "latch disarmed", {kdev_push, kdev_byte}, 9'h133);
    end

    // latch survives unknown and non-latching commands R12
    do_reset();
    wr(1, 0, 8'h60);
    wr(1, 0, 8'h55);
    wr(1, 0, 8'h20);
    chk("R5", "read mode", {kq_push, kq_byte}, 9'h103);
    wr(0, 1, 8'h40);
    chk("R12", "latch kept", mode_o, 8'h40);
    chk("R10", "xlate set", xlate_en, 1);
    wr(1, 0, 8'h60);
    wr(0, 1, 8'h00);
    chk("R10", "xlate clear", xlate_en, 0);

    // output port writes R9
    do_reset();
    wr(1, 0, 8'hD1); wr(0, 1, 8'h03);
    chk("R9", "outp 03 no reset", sys_reset_req, 0);
    chk("R9", "outp 03 a20", a20_o, 1);
    wr(1, 0, 8'hD1); wr(0, 1, 8'h01);
    chk("R9", "outp 01 a20", a20_o, 0);
    chk("R9", "outp 01 no reset", sys_reset_req, 0);
    wr(1, 0, 8'hD0);
    chk("R5", "read outport", {kq_push, kq_byte}, 9'h101);
    wr(1, 0, 8'hDF);
    chk("R8", "a20 on", {a20_o, outport_o}, 9'h103);

    // collision R13
    do_reset();
    wr(1, 0, 8'hD2);
    wr(1, 1, 8'h20);
    chk("R13", "cmd taken", {kq_push, kq_byte}, 9'h103);
    chk("R13", "data dropped", kdev_push, 0);
    chk("R13", "status cmd", status_o[3], 1);
    wr(0, 1, 8'h11);
    chk("R13", "latch still armed", {kq_push, kq_byte}, 9'h111);

    report();
  end
endmodule